// File: doc/BRIEF.md
# Five-Digit Light Timer Segment Driver

This block turns the running counts of three light timers into segment patterns for five seven-segment digits. Green gets two digits and arrives already split into two BCD nibbles. Yellow gets one digit and arrives as a 4-bit value. Red gets two digits, but its count arrives as a plain 7-bit binary number. The block converts that number to tens and units BCD internally before decoding.

The green digits feed common-cathode parts, so a lit segment is a high output. The yellow and red digits feed common-anode parts, so a lit segment is a low output. A zero in a tens place is always drawn as a zero and is never blanked. A red count above 99 shows a dash on both red digits. Every segment output is registered on the system clock, so the displays never see decoder glitches.

Top module: `seg_status_display`

## Requirements
- R1: While `rst_n` is low, every segment output shows all segments off: green outputs read 7'b0000000, while yellow and red outputs read 7'b1111111. This applies from the moment reset is asserted, with no wait for a clock.
- R2: Segment vectors are ordered {g,f,e,d,c,b,a}, with a in bit 0. In lit-high form, the digit shapes are: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F and 9=0x6F. The 6 and the 9 are drawn with tails. Green tens take `grn_bcd[7:4]` and green units take `grn_bcd[3:0]`. Both are driven in lit-high form.
- R3: A red count from 0 to 99 is split into its decimal tens and units. Each of the two red digits shows its shape in lit-low form, which is the bitwise inverse of the R2 value.
- R4: A tens digit of zero, green or red, shows the zero shape and is not blanked. That is 0x3F for green and 0x40 for red.
- R5: A red count from 100 to 127 shows a dash on both red digits. The dash is segment g alone, which in lit-low form is 7'b0111111.
- R6: The yellow digit shows `ylw_val` in lit-low form. For example, a value of 8 gives 7'b0000000.
- R7: Codes 10 to 15 on a green or yellow digit show all segments off in that digit's polarity. That is 0x00 for green and 0x7F for yellow.
- R8: Each output reflects the inputs sampled at the previous rising clock edge. An input change does not reach the outputs before the next rising edge, and it is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grn_bcd | input | 8 | Green count as two BCD digits, tens in the upper nibble |
| ylw_val | input | 4 | Yellow count, one digit |
| red_bin | input | 7 | Red count, binary |
| grn_tens_seg | output | 7 | Green tens segments, lit high |
| grn_ones_seg | output | 7 | Green units segments, lit high |
| ylw_seg | output | 7 | Yellow segments, lit low |
| red_tens_seg | output | 7 | Red tens segments, lit low |
| red_ones_seg | output | 7 | Red units segments, lit low |

## Verification
The bench sweeps 256 input vectors. This sweep takes every red count from 0 to 127, so every conversion result and the whole dash region are covered, including the step from 99 to 100. The same sweep presents every green nibble pair and every yellow code, which separates the valid shapes from the off codes 10 to 15 in both polarities. Directed vectors isolate tens digits of zero, which shows whether leading-zero suppression has crept in. Before each clock edge, the bench also checks that the outputs still hold the old value, which detects any lost or extra register stage. A mid-run reset confirms that the outputs go dark immediately, without waiting for a clock.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [BCD_W-1:0] bcd_t;

  // lit-high form, bit order {g,f,e,d,c,b,a}
  localparam seg_t DASH_HI = 7'b1000000;
  localparam seg_t DARK_HI = 7'b0000000;

  function automatic seg_t shape_hi(input bcd_t code);
    seg_t s;
    case (code)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1101111;
      default: s = DARK_HI;  // R7: codes 10..15 unlit
    endcase
    return s;
  endfunction
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/seg_bin2bcd.sv
module seg_bin2bcd
  import seg_disp_pkg::*;
#(
  parameter int IN_W = 7,
  parameter int MAX_VAL = 99
) (
  input  logic [IN_W-1:0] bin,
  output bcd_t            tens,
  output bcd_t            units,
  output logic            over
);
  localparam int TENS_MAX = MAX_VAL / 10;

  logic [IN_W-1:0] rem;

  // threshold count: tens is the number of multiples of ten not above bin
  always_comb begin
    tens = '0;
    for (int k = 1; k <= TENS_MAX; k++) begin
      if (bin >= IN_W'(10 * k)) tens = BCD_W'(k);
    end
    rem   = bin - IN_W'(int'(tens) * 10);
    units = BCD_W'(rem);
    over  = (bin > IN_W'(MAX_VAL));
  end
endmodule

// File: rtl/seg_glyph_dec.sv
module seg_glyph_dec
  import seg_disp_pkg::*;
#(
  parameter bit LIT_LOW = 1'b0
) (
  input  bcd_t code,
  input  logic dash,
  output seg_t seg
);
  seg_t hi;

  always_comb begin
    hi = dash ? DASH_HI : shape_hi(code);
  end

  generate
    if (LIT_LOW) begin : g_anode
      assign seg = ~hi;
    end else begin : g_cathode
      assign seg = hi;
    end
  endgenerate
endmodule

// File: rtl/seg_out_reg.sv
module seg_out_reg
  import seg_disp_pkg::*;
#(
  parameter seg_t RST_VAL = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  seg_t d,
  output seg_t q
);
  seg_t q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/seg_status_display.sv
module seg_status_display
  import seg_disp_pkg::*;
#(
  parameter int RED_W = 7,
  parameter int RED_MAX = 99
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       grn_bcd,
  input  logic [3:0]       ylw_val,
  input  logic [RED_W-1:0] red_bin,
  output logic [6:0]       grn_tens_seg,
  output logic [6:0]       grn_ones_seg,
  output logic [6:0]       ylw_seg,
  output logic [6:0]       red_tens_seg,
  output logic [6:0]       red_ones_seg
);
  localparam int NUM_DIG = 5;
  // digit slots: 0 green tens, 1 green units, 2 yellow, 3 red tens, 4 red units
  localparam logic [NUM_DIG-1:0] LOW_MASK = 5'b11100;

  logic rst_q_n;
  bcd_t red_tens, red_units;
  logic red_over;
  bcd_t dig_code [NUM_DIG];
  logic dig_dash [NUM_DIG];
  seg_t dig_seg  [NUM_DIG];
  seg_t dig_q    [NUM_DIG];

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  seg_bin2bcd #(.IN_W(RED_W), .MAX_VAL(RED_MAX)) u_conv (
    .bin(red_bin), .tens(red_tens), .units(red_units), .over(red_over)
  );

  always_comb begin
    dig_code[0] = grn_bcd[7:4];
    dig_code[1] = grn_bcd[3:0];
    dig_code[2] = ylw_val;
    dig_code[3] = red_tens;
    dig_code[4] = red_units;
    dig_dash[0] = 1'b0;
    dig_dash[1] = 1'b0;
    dig_dash[2] = 1'b0;
    dig_dash[3] = red_over;
    dig_dash[4] = red_over;
  end

  // reset reaches the output flops directly so R1 holds at once;
  // release follows the synchronised copy
  logic out_rst_n;
  assign out_rst_n = rst_n & rst_q_n;

  generate
    for (genvar i = 0; i < NUM_DIG; i++) begin : g_dig
      seg_glyph_dec #(.LIT_LOW(LOW_MASK[i])) u_dec (
        .code(dig_code[i]), .dash(dig_dash[i]), .seg(dig_seg[i])
      );
      seg_out_reg #(.RST_VAL(LOW_MASK[i] ? ~DARK_HI : DARK_HI)) u_reg (
        .clk(clk), .rst_n(out_rst_n), .d(dig_seg[i]), .q(dig_q[i])
      );
    end
  endgenerate

  assign grn_tens_seg = dig_q[0];
  assign grn_ones_seg = dig_q[1];
  assign ylw_seg      = dig_q[2];
  assign red_tens_seg = dig_q[3];
  assign red_ones_seg = dig_q[4];

  // R3: conversion is exact in range
  p_exact_r3: assert property (@(posedge clk) disable iff (!out_rst_n)
    (red_bin <= RED_W'(RED_MAX)) |->
      (red_tens <= 4'd9 && red_units <= 4'd9 &&
       int'(red_tens) * 10 + int'(red_units) == int'(red_bin)));

  // R5: out-of-range red shows dashes one clock later
  p_dash_r5: assert property (@(posedge clk) disable iff (!out_rst_n)
    (red_bin > RED_W'(RED_MAX)) |=>
      (red_tens_seg == 7'b0111111 && red_ones_seg == 7'b0111111));

  // R4: zero tens stays visible
  p_lead_zero_r4: assert property (@(posedge clk) disable iff (!out_rst_n)
    (grn_bcd[7:4] == 4'd0) |=> (grn_tens_seg == 7'h3F));

  // R7: invalid yellow code is dark in lit-low form
  p_ylw_dark_r7: assert property (@(posedge clk) disable iff (!out_rst_n)
    (ylw_val > 4'd9) |=> (ylw_seg == 7'h7F));

  // R6: yellow eight lights every segment, lit-low
  p_ylw_eight_r6: assert property (@(posedge clk) disable iff (!out_rst_n)
    (ylw_val == 4'd8) |=> ($countones(ylw_seg) == 0));

  // R2: green units one lights b and c only
  p_grn_one_r2: assert property (@(posedge clk) disable iff (!out_rst_n)
    (grn_bcd[3:0] == 4'd1) |=> (grn_ones_seg == 7'h06));
endmodule

// File: tb/seg_status_display_tb.sv
module seg_status_display_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] grn_bcd;
  logic [3:0] ylw_val;
  logic [6:0] red_bin;
  logic [6:0] grn_tens_seg, grn_ones_seg, ylw_seg, red_tens_seg, red_ones_seg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [6:0] exp_q [5];

  always #5 clk = ~clk;

  seg_status_display dut_i (
    .clk(clk), .rst_n(rst_n), .grn_bcd(grn_bcd), .ylw_val(ylw_val),
    .red_bin(red_bin), .grn_tens_seg(grn_tens_seg), .grn_ones_seg(grn_ones_seg),
    .ylw_seg(ylw_seg), .red_tens_seg(red_tens_seg), .red_ones_seg(red_ones_seg)
  );

  function automatic logic [6:0] ref_hi(input int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] g, input logic [3:0] y, input logic [6:0] r);
    int rv;
    rv = int'(r);
    exp_q[0] = ref_hi(int'(g[7:4]));
    exp_q[1] = ref_hi(int'(g[3:0]));
    exp_q[2] = ~ref_hi(int'(y));
    if (rv > 99) begin
      exp_q[3] = 7'b0111111;
      exp_q[4] = 7'b0111111;
    end else begin
      exp_q[3] = ~ref_hi(rv / 10);
      exp_q[4] = ~ref_hi(rv % 10);
    end
  endtask

  task automatic check_all(input logic [7:0] g, input logic [3:0] y, input logic [6:0] r);
    chk(g[7:4] > 9 ? "R7" : (g[7:4] == 0 ? "R4" : "R2"), "green tens", grn_tens_seg, exp_q[0]);
    chk(g[3:0] > 9 ? "R7" : "R2", "green units", grn_ones_seg, exp_q[1]);
    chk(y > 9 ? "R7" : "R6", "yellow", ylw_seg, exp_q[2]);
    chk(r > 99 ? "R5" : (r < 10 ? "R4" : "R3"), "red tens", red_tens_seg, exp_q[3]);
    chk(r > 99 ? "R5" : "R3", "red units", red_ones_seg, exp_q[4]);
  endtask

  // driven just after a falling edge; old value must persist until the next rise
  task automatic apply(input logic [7:0] g, input logic [3:0] y, input logic [6:0] r);
    logic [6:0] old_g1, old_r1;
    old_g1 = exp_q[1];
    old_r1 = exp_q[4];
    @(negedge clk);
    grn_bcd = g; ylw_val = y; red_bin = r;
    #1;
    chk("R8", "hold green units", grn_ones_seg, old_g1);
    chk("R8", "hold red units", red_ones_seg, old_r1);
    model(g, y, r);
    @(negedge clk);
    check_all(g, y, r);
  endtask

  initial begin
    rst_n = 1'b0;
    grn_bcd = 8'h57; ylw_val = 4'd3; red_bin = 7'd42;
    repeat (3) @(negedge clk);
    chk("R1", "reset green tens", grn_tens_seg, 7'h00);
    chk("R1", "reset green units", grn_ones_seg, 7'h00);
    chk("R1", "reset yellow", ylw_seg, 7'h7F);
    chk("R1", "reset red tens", red_tens_seg, 7'h7F);
    chk("R1", "reset red units", red_ones_seg, 7'h7F);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model(grn_bcd, ylw_val, red_bin);
    check_all(grn_bcd, ylw_val, red_bin);

    // directed corners
    apply(8'h05, 4'd8, 7'd7);    // R4 zero tens on both, R6 eight
    apply(8'h00, 4'd0, 7'd0);    // R4 all zeros
    apply(8'h99, 4'd9, 7'd99);   // R3 top of range
    apply(8'h10, 4'd1, 7'd100);  // R5 first dash
    apply(8'h69, 4'd6, 7'd127);  // R5 top, R2 tails
    apply(8'hAF, 4'd15, 7'd10);  // R7 dark codes
    apply(8'h3C, 4'd10, 7'd58);  // R7 mixed

    // sweep
    for (int i = 0; i < 256; i++) begin
      apply(8'(i), 4'(i * 7), 7'(i));
    end

    // asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "async green tens", grn_tens_seg, 7'h00);
    chk("R1", "async yellow", ylw_seg, 7'h7F);
    chk("R1", "async red units", red_ones_seg, 7'h7F);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model(grn_bcd, ylw_val, red_bin);
    check_all(grn_bcd, ylw_val, red_bin);
    apply(8'h42, 4'd4, 7'd63);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule